// File: doc/BRIEF.md
# Diversity Recovery and Reload Sequencer

This controller takes over a packet-processing core whenever the execution-flow checker beside it reports a violation. It walks through a fixed recovery order. First it discards the packet in flight. Then it puts the core into reset and wipes the instruction memory. Next it draws a new code variant at pseudo-random from N functionally equivalent images held in protected on-chip storage. Finally it rewrites both the instruction memory and the checker's graph table from that variant.

While the code words go into instruction memory, the same words are streamed to an external digest engine. The engine's result is compared with the expected digest kept in the leading words of the chosen variant's graph. The core and the checker are released only when the two digests agree. A disagreement restarts recovery with yet another variant. The same load-and-verify path runs once after reset, before the core first executes. The digest engine is used only during a load, so it never slows normal execution.

Top module: `recovery_sequencer`

## Requirements
- R1: After reset, busy_o and core_rst_o are high and mon_en_o is low. The block then performs a load and an integrity check of a variant, without any packet drop, before it releases the core for the first time.
- R2: A violation_i sampled while running produces a pkt_drop_o pulse of exactly one cycle in the next cycle. The steps then follow strictly in this order: packet drop, core reset asserted, instruction-memory clear (imem_clr_o high for CLR_CYC cycles), variant pick, graph table load, code load.
- R3: Once raised during a recovery, core_rst_o stays high without a gap until the core is released, including across integrity retries.
- R4: Assume hash_ready_i is always high and hash_done_i arrives in the cycle after the last code word is accepted. Then busy_o lasts 12 + GRAPH_WORDS + IMG_WORDS cycles, counted from the cycle after the violation; at defaults this is 40. The first load after reset keeps busy_o high for 11 + GRAPH_WORDS + IMG_WORDS cycles.
- R5: Every recovery picks a variant different from the one currently loaded. The pick comes from a free-running LFSR, and over repeated recoveries every variant is reachable. active_ver_o does not change while the core runs.
- R6: The graph load writes word a of the chosen variant's graph source to graph address a, for a = 0 to GRAPH_WORDS-1. The code load writes word a of the chosen variant's code source to instruction address a. Both loads take their words through an N-to-1 selection by active_ver_o. Variant v occupies bits [v*DATA_W +: DATA_W] of each bank input.
- R7: Every code word is offered on the digest stream with hash_valid_o. The offered word and hash_last_o stay unchanged while hash_ready_i is low, and hash_last_o marks word IMG_WORDS-1. An instruction-memory write happens only in a cycle where the word is accepted.
- R8: The expected digest is made of graph words 0 to DIGEST_W/DATA_W-1, with word k placed at bits [k*DATA_W +: DATA_W]. If hash_digest_i, taken at hash_done_i, equals it, the core is released: busy_o low, core_rst_o low, mon_en_o high.
- R9: On a digest mismatch the core stays in reset and recovery restarts at the core-reset step. It does so without a new packet drop and with a different variant. Each retry adds 11 + GRAPH_WORDS + IMG_WORDS cycles.
- R10: hash_valid_o is never high while the core runs.
- R11: A violation_i that arrives while busy_o is high is ignored. It causes no packet drop and does not change the recovery timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| violation_i | input | 1 | Execution-flow violation from the checker |
| busy_o | output | 1 | Recovery or load in progress |
| mon_en_o | output | 1 | Core and checker may run |
| pkt_drop_o | output | 1 | Clear packet buffer and drop current packet |
| core_rst_o | output | 1 | Core register and stack reset |
| imem_clr_o | output | 1 | Instruction memory clear |
| imem_we_o | output | 1 | Instruction memory write enable |
| imem_addr_o | output | IA_W (4) | Instruction memory write address |
| imem_wdata_o | output | DATA_W (32) | Instruction memory write data |
| graph_we_o | output | 1 | Graph table write enable |
| graph_addr_o | output | GA_W (4) | Graph table write address |
| graph_wdata_o | output | DATA_W (32) | Graph table write data |
| active_ver_o | output | VER_W (2) | Variant currently loaded |
| src_addr_o | output | CNT_W (4) | Word address into the stored images and graphs |
| code_bank_i | input | N_IMG*DATA_W (128) | Code word at src_addr_o, one slice per variant |
| graph_bank_i | input | N_IMG*DATA_W (128) | Graph word at src_addr_o, one slice per variant |
| hash_valid_o | output | 1 | Digest stream word valid |
| hash_ready_i | input | 1 | Digest engine accepts word |
| hash_word_o | output | DATA_W (32) | Digest stream word |
| hash_last_o | output | 1 | Final word of the image |
| hash_done_i | input | 1 | Digest result strobe |
| hash_digest_i | input | DIGEST_W (256) | Digest result |

## Verification
Some properties are checked by assertions on every cycle:
- the single-cycle drop pulse and that it is raised only from the running state;
- that core reset is held continuously while busy;
- that the stream is stable under backpressure and that writes occur only on accepted words;
- that the stream is silent and the variant unchanged while running;
- that violations are ignored while busy.

Other properties only the bench scenarios can show: whether the contents reloaded into both memories really belong to the selected variant, that each recovery picks a variant different from the previous one and that all variants appear, the exact busy durations, and the retry path, in which corrupted graph digests force repeated loads until an intact variant is chosen.

// File: rtl/rs_pkg.sv
package rs_pkg;
  typedef enum logic [3:0] {
    ST_RUN,
    ST_DROP,
    ST_CRST,
    ST_ICLR,
    ST_PICK,
    ST_GRAPH,
    ST_CODE,
    ST_WAIT,
    ST_CHECK
  } rs_state_e;
endpackage

// File: rtl/rs_ver_pick.sv
module rs_ver_pick #(
  parameter int unsigned N_IMG = 4,
  parameter int unsigned LFSR_W = 16,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
  localparam int unsigned VER_W = $clog2(N_IMG)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             first_i,
  input  logic [VER_W-1:0] cur_ver_i,
  output logic [VER_W-1:0] pick_o
);
  logic [LFSR_W-1:0] lfsr_q;

  // free running, never zero
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lfsr_q <= LFSR_W'(16'hACE1);
    else         lfsr_q <= {1'b0, lfsr_q[LFSR_W-1:1]} ^ (lfsr_q[0] ? LFSR_TAPS : '0);
  end

  // offset 1..N-1 from current variant guarantees a different pick in one cycle
  always_comb begin
    if (first_i)
      pick_o = VER_W'(lfsr_q % LFSR_W'(N_IMG));
    else
      pick_o = VER_W'((LFSR_W'(cur_ver_i) + (lfsr_q % LFSR_W'(N_IMG - 1)) + LFSR_W'(1))
                      % LFSR_W'(N_IMG));
  end
endmodule

// File: rtl/rs_src_mux.sv
module rs_src_mux #(
  parameter int unsigned N_IMG = 4,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned VER_W = $clog2(N_IMG)
) (
  input  logic [N_IMG*DATA_W-1:0] bank_i,
  input  logic [VER_W-1:0]        sel_i,
  output logic [DATA_W-1:0]       word_o
);
  logic [DATA_W-1:0] words [N_IMG];

  for (genvar g = 0; g < N_IMG; g++) begin : g_slice
    assign words[g] = bank_i[g*DATA_W +: DATA_W];
  end

  assign word_o = words[sel_i];
endmodule

// File: rtl/rs_dig_chk.sv
module rs_dig_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DIGEST_W = 256,
  parameter int unsigned IDX_W = 4,
  localparam int unsigned DIG_WORDS = DIGEST_W / DATA_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cap_en_i,
  input  logic [IDX_W-1:0]    idx_i,
  input  logic [DATA_W-1:0]   word_i,
  input  logic                dig_ld_i,
  input  logic [DIGEST_W-1:0] dig_i,
  output logic                match_o
);
  logic [DIGEST_W-1:0] exp_w;
  logic [DIGEST_W-1:0] act_q;

  // expected digest sits in the leading graph words
  for (genvar k = 0; k < DIG_WORDS; k++) begin : g_cap
    logic [DATA_W-1:0] w_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               w_q <= '0;
      else if (cap_en_i && idx_i == IDX_W'(k))   w_q <= word_i;
    end
    assign exp_w[k*DATA_W +: DATA_W] = w_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       act_q <= '0;
    else if (dig_ld_i) act_q <= dig_i;
  end

  assign match_o = (exp_w == act_q);
endmodule

// File: rtl/recovery_sequencer.sv
module recovery_sequencer
  import rs_pkg::*;
#(
  parameter int unsigned N_IMG       = 4,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned IMG_WORDS   = 16,
  parameter int unsigned GRAPH_WORDS = 12,
  parameter int unsigned DIGEST_W    = 256,
  parameter int unsigned RST_CYC     = 4,
  parameter int unsigned CLR_CYC     = 4,
  parameter int unsigned LFSR_W      = 16,
  localparam int unsigned VER_W = $clog2(N_IMG),
  localparam int unsigned IA_W  = $clog2(IMG_WORDS),
  localparam int unsigned GA_W  = $clog2(GRAPH_WORDS),
  localparam int unsigned MAX_A = (IMG_WORDS > GRAPH_WORDS) ? IMG_WORDS : GRAPH_WORDS,
  localparam int unsigned MAX_B = (RST_CYC > CLR_CYC) ? RST_CYC : CLR_CYC,
  localparam int unsigned CNT_W = $clog2((MAX_A > MAX_B) ? MAX_A : MAX_B)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    violation_i,
  output logic                    busy_o,
  output logic                    mon_en_o,
  output logic                    pkt_drop_o,
  output logic                    core_rst_o,
  output logic                    imem_clr_o,
  output logic                    imem_we_o,
  output logic [IA_W-1:0]         imem_addr_o,
  output logic [DATA_W-1:0]       imem_wdata_o,
  output logic                    graph_we_o,
  output logic [GA_W-1:0]         graph_addr_o,
  output logic [DATA_W-1:0]       graph_wdata_o,
  output logic [VER_W-1:0]        active_ver_o,
  output logic [CNT_W-1:0]        src_addr_o,
  input  logic [N_IMG*DATA_W-1:0] code_bank_i,
  input  logic [N_IMG*DATA_W-1:0] graph_bank_i,
  output logic                    hash_valid_o,
  input  logic                    hash_ready_i,
  output logic [DATA_W-1:0]       hash_word_o,
  output logic                    hash_last_o,
  input  logic                    hash_done_i,
  input  logic [DIGEST_W-1:0]     hash_digest_i
);
  rs_state_e         st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [VER_W-1:0]  ver_q, pick;
  logic              have_q, ld_ver, match;
  logic [DATA_W-1:0] code_w, graph_w;

  rs_ver_pick #(.N_IMG(N_IMG), .LFSR_W(LFSR_W)) u_pick (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .first_i   (!have_q),
    .cur_ver_i (ver_q),
    .pick_o    (pick)
  );

  rs_src_mux #(.N_IMG(N_IMG), .DATA_W(DATA_W)) u_code_mux (
    .bank_i (code_bank_i),
    .sel_i  (ver_q),
    .word_o (code_w)
  );

  rs_src_mux #(.N_IMG(N_IMG), .DATA_W(DATA_W)) u_graph_mux (
    .bank_i (graph_bank_i),
    .sel_i  (ver_q),
    .word_o (graph_w)
  );

  rs_dig_chk #(.DATA_W(DATA_W), .DIGEST_W(DIGEST_W), .IDX_W(CNT_W)) u_dig (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cap_en_i (st_q == ST_GRAPH),
    .idx_i    (cnt_q),
    .word_i   (graph_w),
    .dig_ld_i (st_q == ST_WAIT && hash_done_i),
    .dig_i    (hash_digest_i),
    .match_o  (match)
  );

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    ld_ver = 1'b0;
    unique case (st_q)
      ST_RUN:   if (violation_i) st_d = ST_DROP;
      ST_DROP:  begin st_d = ST_CRST; cnt_d = '0; end
      ST_CRST:
        if (cnt_q == CNT_W'(RST_CYC - 1)) begin st_d = ST_ICLR; cnt_d = '0; end
        else cnt_d = cnt_q + CNT_W'(1);
      ST_ICLR:
        if (cnt_q == CNT_W'(CLR_CYC - 1)) begin st_d = ST_PICK; cnt_d = '0; end
        else cnt_d = cnt_q + CNT_W'(1);
      ST_PICK:  begin ld_ver = 1'b1; st_d = ST_GRAPH; cnt_d = '0; end
      ST_GRAPH:
        if (cnt_q == CNT_W'(GRAPH_WORDS - 1)) begin st_d = ST_CODE; cnt_d = '0; end
        else cnt_d = cnt_q + CNT_W'(1);
      ST_CODE:
        if (hash_ready_i) begin
          if (cnt_q == CNT_W'(IMG_WORDS - 1)) begin st_d = ST_WAIT; cnt_d = '0; end
          else cnt_d = cnt_q + CNT_W'(1);
        end
      ST_WAIT:  if (hash_done_i) st_d = ST_CHECK;
      ST_CHECK: begin st_d = match ? ST_RUN : ST_CRST; cnt_d = '0; end
      default:  begin st_d = ST_CRST; cnt_d = '0; end
    endcase
  end

  // startup enters at the core-reset step: load and check before first run
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_CRST;
      cnt_q  <= '0;
      ver_q  <= '0;
      have_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      if (ld_ver) begin
        ver_q  <= pick;
        have_q <= 1'b1;
      end
    end
  end

  assign busy_o        = (st_q != ST_RUN);
  assign mon_en_o      = (st_q == ST_RUN);
  assign pkt_drop_o    = (st_q == ST_DROP);
  assign core_rst_o    = !(st_q inside {ST_RUN, ST_DROP});
  assign imem_clr_o    = (st_q == ST_ICLR);
  assign graph_we_o    = (st_q == ST_GRAPH);
  assign graph_addr_o  = GA_W'(cnt_q);
  assign graph_wdata_o = graph_w;
  assign hash_valid_o  = (st_q == ST_CODE);
  assign hash_word_o   = code_w;
  assign hash_last_o   = hash_valid_o && (cnt_q == CNT_W'(IMG_WORDS - 1));
  assign imem_we_o     = hash_valid_o && hash_ready_i;
  assign imem_addr_o   = IA_W'(cnt_q);
  assign imem_wdata_o  = code_w;
  assign src_addr_o    = cnt_q;
  assign active_ver_o  = ver_q;
endmodule

// File: rtl/recovery_sequencer_chk.sv
module recovery_sequencer_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned VER_W  = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              violation_i,
  input logic              busy_o,
  input logic              mon_en_o,
  input logic              pkt_drop_o,
  input logic              core_rst_o,
  input logic              imem_clr_o,
  input logic              imem_we_o,
  input logic              graph_we_o,
  input logic [VER_W-1:0]  active_ver_o,
  input logic              hash_valid_o,
  input logic              hash_ready_i,
  input logic [DATA_W-1:0] hash_word_o,
  input logic              hash_last_o
);
  AST_DROP_FROM_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_drop_o |-> $past(mon_en_o) && $past(violation_i)); // R2
  AST_DROP_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_drop_o |=> !pkt_drop_o && core_rst_o); // R2
  AST_STEP_STROBES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({pkt_drop_o, imem_clr_o, graph_we_o, hash_valid_o})); // R2
  AST_CORE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_rst_o |=> core_rst_o || mon_en_o); // R3
  AST_VER_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mon_en_o && $past(mon_en_o) |-> $stable(active_ver_o)); // R5
  AST_HASH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hash_valid_o && !hash_ready_i |=> hash_valid_o && $stable(hash_word_o) && $stable(hash_last_o)); // R7
  AST_WRITE_ON_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    imem_we_o |-> hash_valid_o && hash_ready_i); // R7
  AST_RUN_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mon_en_o |-> !core_rst_o && !busy_o); // R8
  AST_HASH_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hash_valid_o |-> busy_o && core_rst_o); // R10
  AST_IGNORE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && violation_i |=> !pkt_drop_o); // R11
endmodule

bind recovery_sequencer recovery_sequencer_chk #(.DATA_W(DATA_W), .VER_W(VER_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .violation_i  (violation_i),
  .busy_o       (busy_o),
  .mon_en_o     (mon_en_o),
  .pkt_drop_o   (pkt_drop_o),
  .core_rst_o   (core_rst_o),
  .imem_clr_o   (imem_clr_o),
  .imem_we_o    (imem_we_o),
  .graph_we_o   (graph_we_o),
  .active_ver_o (active_ver_o),
  .hash_valid_o (hash_valid_o),
  .hash_ready_i (hash_ready_i),
  .hash_word_o  (hash_word_o),
  .hash_last_o  (hash_last_o)
);

// File: tb/recovery_sequencer_bench.sv
module recovery_sequencer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N     = 4;
  localparam int DW    = 32;
  localparam int CW    = 16;
  localparam int GW    = 12;
  localparam int DGW   = 256;
  localparam int DIGW  = DGW / DW;
  localparam int CNT_W = 4;
  localparam int VER_W = 2;
  localparam int LOAD  = 11 + GW + CW;

  logic clk_i = 1'b0, rst_ni = 1'b0, violation_i = 1'b0;
  logic busy_o, mon_en_o, pkt_drop_o, core_rst_o, imem_clr_o, imem_we_o, graph_we_o;
  logic [3:0] imem_addr_o, graph_addr_o;
  logic [DW-1:0] imem_wdata_o, graph_wdata_o, hash_word_o;
  logic [VER_W-1:0] active_ver_o;
  logic [CNT_W-1:0] src_addr_o;
  logic [N*DW-1:0] code_bank, graph_bank;
  logic hash_valid_o, hash_ready = 1'b1, hash_last_o, hash_done;
  logic [DGW-1:0] hash_digest, acc;
  logic [N-1:0] bad_mask = '0;
  bit rdy_mode = 1'b0;

  int n_tests = 0, n_fail = 0;
  int cyc = 0, drop_cnt, clr_rise, rst_rise, t_drop, t_rst, t_clr, t_gw, t_iw, hv_idle = 0;
  logic prev_clr = 1'b0, prev_rst = 1'b0;
  logic [DW-1:0] imem_m [CW];
  logic [DW-1:0] graph_m [GW];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  recovery_sequencer u_recovery_sequencer (
    .clk_i, .rst_ni, .violation_i, .busy_o, .mon_en_o, .pkt_drop_o, .core_rst_o,
    .imem_clr_o, .imem_we_o, .imem_addr_o, .imem_wdata_o, .graph_we_o, .graph_addr_o,
    .graph_wdata_o, .active_ver_o, .src_addr_o,
    .code_bank_i(code_bank), .graph_bank_i(graph_bank),
    .hash_valid_o, .hash_ready_i(hash_ready), .hash_word_o, .hash_last_o,
    .hash_done_i(hash_done), .hash_digest_i(hash_digest)
  );

  function automatic logic [DW-1:0] code_word(int v, int a);
    return DW'((v + 1) * 32'h0107_0000) ^ DW'(a * 32'h0000_9E37) ^ DW'(32'hA500_0000 + v * 7 + a);
  endfunction

  function automatic logic [DGW-1:0] fold(logic [DGW-1:0] s, logic [DW-1:0] w);
    return {s[DGW-DW-1:0], s[DGW-1:DGW-DW] ^ w};
  endfunction

  function automatic logic [DGW-1:0] img_digest(int v);
    logic [DGW-1:0] s = '0;
    for (int a = 0; a < CW; a++) s = fold(s, code_word(v, a));
    return s;
  endfunction

  function automatic logic [DW-1:0] graph_word(int v, int a, bit bad);
    logic [DGW-1:0] d;
    if (a < DIGW) begin
      d = img_digest(v);
      return d[a*DW +: DW] ^ DW'((bad && a == 0) ? 1 : 0);
    end
    return {8'(8'hC0 ^ v), 8'(a), 16'h5A5A};
  endfunction

  // protected image storage stand-in
  always_comb begin
    for (int v = 0; v < N; v++) begin
      code_bank[v*DW +: DW]  = code_word(v, int'(src_addr_o));
      graph_bank[v*DW +: DW] = graph_word(v, int'(src_addr_o), bad_mask[v]);
    end
  end

  // digest engine stand-in
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc <= '0; hash_done <= 1'b0; hash_digest <= '0;
    end else begin
      hash_done <= 1'b0;
      if (hash_valid_o && hash_ready) begin
        if (hash_last_o) begin
          hash_digest <= fold(acc, hash_word_o);
          hash_done   <= 1'b1;
          acc         <= '0;
        end else acc <= fold(acc, hash_word_o);
      end
    end
  end

  // memory models and step timestamps, sampled mid-cycle
  always @(negedge clk_i) begin
    cyc++;
    if (imem_clr_o) for (int a = 0; a < CW; a++) imem_m[a] = 32'hDEAD_DEAD;
    if (imem_we_o) imem_m[imem_addr_o] = imem_wdata_o;
    if (graph_we_o) graph_m[graph_addr_o] = graph_wdata_o;
    if (pkt_drop_o) begin drop_cnt++; if (t_drop < 0) t_drop = cyc; end
    if (core_rst_o && t_rst < 0) t_rst = cyc;
    if (imem_clr_o && t_clr < 0) t_clr = cyc;
    if (graph_we_o && t_gw < 0) t_gw = cyc;
    if (imem_we_o && t_iw < 0) t_iw = cyc;
    if (imem_clr_o && !prev_clr) clr_rise++;
    if (core_rst_o && !prev_rst) rst_rise++;
    if (hash_valid_o && !busy_o) hv_idle++;
    prev_clr = imem_clr_o;
    prev_rst = core_rst_o;
  end

  initial forever begin
    @(negedge clk_i);
    hash_ready = rdy_mode ? ($urandom % 3 != 0) : 1'b1;
  end

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clr_track();
    drop_cnt = 0; clr_rise = 0; rst_rise = 0;
    t_drop = -1; t_rst = -1; t_clr = -1; t_gw = -1; t_iw = -1;
  endtask

  task automatic check_content(string req);
    int bad_i = 0, bad_g = 0;
    int v = int'(active_ver_o);
    for (int a = 0; a < CW; a++) if (imem_m[a] !== code_word(v, a)) bad_i++;
    for (int a = 0; a < GW; a++) if (graph_m[a] !== graph_word(v, a, bad_mask[v])) bad_g++;
    check(bad_i == 0, req, "code words wrong", bad_i, 0);
    check(bad_g == 0, req, "graph words wrong", bad_g, 0);
  endtask

  // violation pulse; optional second pulse mid-recovery
  task automatic do_violation(int mid, output int dur);
    @(negedge clk_i); violation_i = 1'b1;
    @(negedge clk_i); violation_i = 1'b0;
    dur = 0;
    while (busy_o) begin
      @(negedge clk_i);
      dur++;
      violation_i = (dur == mid);
    end
    violation_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int dur, prev, n;
    bit [N-1:0] seen;
    void'($urandom(32'd20241));
    clr_track();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1: reset state
    check(busy_o && core_rst_o && !mon_en_o, "R1", "reset state busy/core_rst/!mon_en",
          {busy_o, core_rst_o, mon_en_o}, 3'b110);
    n = 0;
    while (busy_o) begin @(negedge clk_i); n++; end
    check(n == LOAD, "R4", "startup load cycles", n, LOAD);
    check(drop_cnt == 0, "R1", "no drop at startup", drop_cnt, 0);
    check(mon_en_o && !core_rst_o, "R8", "released after startup", mon_en_o, 1);
    check_content("R1");
    seen = '0;
    seen[active_ver_o] = 1'b1;

    // directed recovery
    prev = int'(active_ver_o);
    clr_track();
    do_violation(-1, dur);
    check(dur == 12 + GW + CW, "R4", "recovery busy cycles", dur, 12 + GW + CW);
    check(drop_cnt == 1, "R2", "drop pulse cycles", drop_cnt, 1);
    check(t_drop >= 0 && t_drop < t_rst && t_rst < t_clr && t_clr < t_gw && t_gw < t_iw,
          "R2", "step order drop<rst<clr<graph<code", t_iw, t_gw + GW);
    check(t_iw - t_clr == 4 + 1 + GW, "R6", "graph load length before code", t_iw - t_clr, 5 + GW);
    check(int'(active_ver_o) != prev, "R5", "new variant differs", active_ver_o, prev);
    check(rst_rise == 1, "R3", "core reset rises once", rst_rise, 1);
    check(mon_en_o && !core_rst_o, "R8", "released after match", mon_en_o, 1);
    check_content("R6");
    seen[active_ver_o] = 1'b1;

    // random mix: backpressure and mid-recovery violations
    for (int it = 0; it < 14; it++) begin
      int mid;
      rdy_mode = ($urandom % 2) == 1;
      mid = ($urandom % 2) ? int'($urandom % 30) + 1 : -1;
      prev = int'(active_ver_o);
      clr_track();
      do_violation(mid, dur);
      if (!rdy_mode)
        check(dur == 12 + GW + CW, "R11", "duration with ignored violation", dur, 12 + GW + CW);
      else
        check(dur >= 12 + GW + CW, "R7", "duration under backpressure", dur, 12 + GW + CW);
      check(drop_cnt == 1, "R11", "single drop per recovery", drop_cnt, 1);
      check(int'(active_ver_o) != prev, "R5", "variant differs from previous", active_ver_o, prev);
      check_content("R7");
      seen[active_ver_o] = 1'b1;
      repeat ($urandom % 4) @(negedge clk_i);
    end
    rdy_mode = 1'b0;
    check(seen == '1, "R5", "all variants reached", seen, 4'hF);

    // integrity failures: only one variant intact
    begin
      int retries = 0;
      for (int k = 0; k < 6; k++) begin
        int good = (int'(active_ver_o) + 1 + k % (N - 1)) % N;
        bad_mask = '1;
        bad_mask[good] = 1'b0;
        clr_track();
        do_violation(-1, dur);
        check(int'(active_ver_o) == good, "R9", "settles on intact variant", active_ver_o, good);
        check(drop_cnt == 1, "R9", "no extra drop on retry", drop_cnt, 1);
        check(rst_rise == 1, "R3", "core reset held across retries", rst_rise, 1);
        check(dur == 12 + GW + CW + LOAD * (clr_rise - 1), "R9", "retry timing",
              dur, 12 + GW + CW + LOAD * (clr_rise - 1));
        check_content("R8");
        if (clr_rise > 1) retries++;
      end
      check(retries > 0, "R9", "mismatch triggered a retry", retries, 1);
      bad_mask = '0;
    end

    repeat (5) @(negedge clk_i);
    check(hv_idle == 0, "R10", "digest stream idle while running", hv_idle, 0);
    check(mon_en_o && !busy_o, "R8", "final run state", mon_en_o, 1);
    finish_run();
  end
endmodule